// File: doc/BRIEF.md
# General-Purpose I/O Port Register

This block is one 8-bit general-purpose I/O port seen by a processor core as a special function register. It holds the output data latch and three per-pin configuration registers: driver mode (open-drain or push-pull), input mode (analog or digital) and a skip flag that tells the crossbar to pass the pin by. From these, together with per-pin override, value and SMBus flags supplied by the crossbar, it computes the output-enable, output value and digital-input-enable sent to each pad cell.

The core reaches the port through a small SFR bus: a register address, a whole-byte write, single-bit set and clear on the data register, a read strobe and a qualifier that marks the read half of a read-modify-write instruction. An ordinary read of the data register returns the live pin level. A qualified read returns the output latch instead, so that bitwise and arithmetic instructions modify the value the core last wrote rather than whatever the pin happens to show.

Top module: `gpio_port_reg`

## Requirements
- R1: After reset the data latch is all ones, every pin is open-drain (driver-mode bit 0), every pin is digital (input-mode bit 1), no pin is skipped, and the read data output is 0.
- R2: Register addresses are 0 = data latch, 1 = driver mode (1 = push-pull), 2 = input mode (1 = digital), 3 = skip (1 = skipped); a byte write stores the write data in the addressed register, and a read of addresses 1 to 3 returns that register.
- R3: A bit set or bit clear at address 0 changes only the latch bit selected by the bit index; a byte write in the same cycle takes priority, and bit set or clear at any other address changes nothing.
- R4: A read of address 0 without the read-modify-write qualifier returns the pad input levels, one cycle after the read strobe; the read data output holds its value in cycles with no read strobe.
- R5: A read of address 0 with the read-modify-write qualifier returns the data latch, not the pad level.
- R6: A digital open-drain pin has output-enable equal to the inverse of its output source; a digital push-pull pin always has output-enable 1; the pad output value always equals the output source.
- R7: A pin whose crossbar override is active and whose SMBus flag is set is driven open-drain whatever its driver-mode bit.
- R8: A pin in analog input mode (input-mode bit 0) has output-enable 0, digital-input-enable 0, and reads as 0 in an ordinary data read.
- R9: When a pin is not skipped and its crossbar override is asserted, the crossbar value is the output source; otherwise the data latch bit is.
- R10: The skip flags and digital-input-enables are presented on output ports that follow the skip and input-mode registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 2 | Register address |
| busWrData | input | 8 | Byte write data |
| busByteWr | input | 1 | Byte write strobe |
| busBitSet | input | 1 | Set one latch bit |
| busBitClr | input | 1 | Clear one latch bit |
| busBitIdx | input | 3 | Bit index for set and clear |
| busRd | input | 1 | Read strobe |
| busRmw | input | 1 | Read belongs to a read-modify-write instruction |
| busRdData | output | 8 | Registered read data |
| xbarOvr | input | 8 | Per-pin peripheral override request |
| xbarVal | input | 8 | Per-pin peripheral output value |
| xbarSmb | input | 8 | Per-pin SMBus signal flag |
| padIn | input | 8 | Pad input levels |
| padOe | output | 8 | Pad output enables |
| padOut | output | 8 | Pad output values |
| padDigEn | output | 8 | Pad digital input enables |
| pinSkip | output | 8 | Skip flags toward the crossbar |

## Verification
The bench drives pins whose latch and pad levels disagree, so a design that mixes up the two read sources returns the pad value on a read-modify-write read or the latch on a plain read. It puts push-pull pins under an SMBus override and checks that a high output turns the driver off; a design without the override would drive the bus high. It mixes skipped and overridden pins, where a design that ignores the skip flag lets the peripheral value through, and it sets input-mode bits to analog to catch a driver left on or a nonzero read. Bit set and clear on other addresses, and a byte write coinciding with a bit clear, expose a decoder that lets the wrong strobe win.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  localparam int ADDR_LATCH    = 0;
  localparam int ADDR_PUSHPULL = 1;
  localparam int ADDR_DIGITAL  = 2;
  localparam int ADDR_SKIP     = 3;

  typedef enum logic [2:0] {
    SRC_PIN,
    SRC_LATCH,
    SRC_PUSHPULL,
    SRC_DIGITAL,
    SRC_SKIP
  } rdSrc_e;

  typedef struct packed {
    logic   ldLatch;
    logic   ldPushPull;
    logic   ldDigital;
    logic   ldSkip;
    logic   setBit;
    logic   clrBit;
    logic   capture;
    rdSrc_e rdSrc;
  } portStrobes_t;

endpackage

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int PIN_COUNT = 8,
  parameter int ADDR_W    = 2,
  localparam int IDX_W    = $clog2(PIN_COUNT)
) (
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 busByteWr,
  input  logic                 busBitSet,
  input  logic                 busBitClr,
  input  logic [IDX_W-1:0]     busBitIdx,
  input  logic                 busRd,
  input  logic                 busRmw,
  output portStrobes_t         strobes,
  output logic [PIN_COUNT-1:0] bitMask
);

  logic atLatch;

  assign atLatch = (busAddr == ADDR_W'(ADDR_LATCH));
  assign bitMask = PIN_COUNT'(1) << busBitIdx;

  always_comb begin
    strobes         = '0;
    strobes.rdSrc   = SRC_PIN;
    strobes.capture = busRd;

    // byte writes go to whichever register is addressed
    if (busByteWr) begin
      unique case (busAddr)
        ADDR_W'(ADDR_LATCH):    strobes.ldLatch    = 1'b1;
        ADDR_W'(ADDR_PUSHPULL): strobes.ldPushPull = 1'b1;
        ADDR_W'(ADDR_DIGITAL):  strobes.ldDigital  = 1'b1;
        default:                strobes.ldSkip     = 1'b1;
      endcase
    end

    // single-bit operations only touch the data latch and lose to a byte write
    strobes.setBit = busBitSet & atLatch & ~busByteWr;
    strobes.clrBit = busBitClr & atLatch & ~busByteWr & ~busBitSet;

    unique case (busAddr)
      ADDR_W'(ADDR_LATCH):    strobes.rdSrc = busRmw ? SRC_LATCH : SRC_PIN;
      ADDR_W'(ADDR_PUSHPULL): strobes.rdSrc = SRC_PUSHPULL;
      ADDR_W'(ADDR_DIGITAL):  strobes.rdSrc = SRC_DIGITAL;
      default:                strobes.rdSrc = SRC_SKIP;
    endcase
  end

endmodule

// File: rtl/gpio_port_datapath.sv
module gpio_port_datapath
  import gpio_port_pkg::*;
#(
  parameter int PIN_COUNT = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  portStrobes_t         strobes,
  input  logic [PIN_COUNT-1:0] bitMask,
  input  logic [PIN_COUNT-1:0] wrData,
  input  logic [PIN_COUNT-1:0] padIn,
  input  logic [PIN_COUNT-1:0] xbarOvr,
  input  logic [PIN_COUNT-1:0] xbarVal,
  input  logic [PIN_COUNT-1:0] xbarSmb,
  output logic [PIN_COUNT-1:0] rdData,
  output logic [PIN_COUNT-1:0] padOe,
  output logic [PIN_COUNT-1:0] padOut,
  output logic [PIN_COUNT-1:0] padDigEn,
  output logic [PIN_COUNT-1:0] pinSkip
);

  logic [PIN_COUNT-1:0] latchQ;
  logic [PIN_COUNT-1:0] pushPullQ;
  logic [PIN_COUNT-1:0] digitalQ;
  logic [PIN_COUNT-1:0] skipQ;
  logic [PIN_COUNT-1:0] pinLevel;
  logic [PIN_COUNT-1:0] rdNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      latchQ    <= '1;
      pushPullQ <= '0;
      digitalQ  <= '1;
      skipQ     <= '0;
    end else begin
      if (strobes.ldLatch)        latchQ <= wrData;
      else if (strobes.setBit)    latchQ <= latchQ | bitMask;
      else if (strobes.clrBit)    latchQ <= latchQ & ~bitMask;
      if (strobes.ldPushPull) pushPullQ <= wrData;
      if (strobes.ldDigital)  digitalQ  <= wrData;
      if (strobes.ldSkip)     skipQ     <= wrData;
    end
  end

  assign pinLevel = padIn & digitalQ;

  always_comb begin
    unique case (strobes.rdSrc)
      SRC_LATCH:    rdNext = latchQ;
      SRC_PUSHPULL: rdNext = pushPullQ;
      SRC_DIGITAL:  rdNext = digitalQ;
      SRC_SKIP:     rdNext = skipQ;
      default:      rdNext = pinLevel;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)                rdData <= '0;
    else if (strobes.capture) rdData <= rdNext;
  end

  for (genvar p = 0; p < PIN_COUNT; p++) begin : g_pin
    logic periphOwns;
    logic srcVal;
    logic openDrain;

    assign periphOwns = xbarOvr[p] & ~skipQ[p];
    assign srcVal     = periphOwns ? xbarVal[p] : latchQ[p];
    assign openDrain  = ~pushPullQ[p] | (periphOwns & xbarSmb[p]);
    assign padOut[p]  = srcVal;
    assign padOe[p]   = digitalQ[p] & (openDrain ? ~srcVal : 1'b1);
  end

  assign padDigEn = digitalQ;
  assign pinSkip  = skipQ;

endmodule

// File: rtl/gpio_port_reg.sv
module gpio_port_reg
  import gpio_port_pkg::*;
#(
  parameter int PIN_COUNT = 8,
  parameter int ADDR_W    = 2,
  localparam int IDX_W    = $clog2(PIN_COUNT)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [PIN_COUNT-1:0] busWrData,
  input  logic                 busByteWr,
  input  logic                 busBitSet,
  input  logic                 busBitClr,
  input  logic [IDX_W-1:0]     busBitIdx,
  input  logic                 busRd,
  input  logic                 busRmw,
  output logic [PIN_COUNT-1:0] busRdData,
  input  logic [PIN_COUNT-1:0] xbarOvr,
  input  logic [PIN_COUNT-1:0] xbarVal,
  input  logic [PIN_COUNT-1:0] xbarSmb,
  input  logic [PIN_COUNT-1:0] padIn,
  output logic [PIN_COUNT-1:0] padOe,
  output logic [PIN_COUNT-1:0] padOut,
  output logic [PIN_COUNT-1:0] padDigEn,
  output logic [PIN_COUNT-1:0] pinSkip
);

  portStrobes_t         strobes;
  logic [PIN_COUNT-1:0] bitMask;

  gpio_port_ctrl #(.PIN_COUNT(PIN_COUNT), .ADDR_W(ADDR_W)) u_ctrl (
    .busAddr  (busAddr),
    .busByteWr(busByteWr),
    .busBitSet(busBitSet),
    .busBitClr(busBitClr),
    .busBitIdx(busBitIdx),
    .busRd    (busRd),
    .busRmw   (busRmw),
    .strobes  (strobes),
    .bitMask  (bitMask)
  );

  gpio_port_datapath #(.PIN_COUNT(PIN_COUNT)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .bitMask (bitMask),
    .wrData  (busWrData),
    .padIn   (padIn),
    .xbarOvr (xbarOvr),
    .xbarVal (xbarVal),
    .xbarSmb (xbarSmb),
    .rdData  (busRdData),
    .padOe   (padOe),
    .padOut  (padOut),
    .padDigEn(padDigEn),
    .pinSkip (pinSkip)
  );

endmodule

// File: rtl/gpio_port_checker.sv
module gpio_port_checker #(
  parameter int PIN_COUNT = 8,
  parameter int ADDR_W    = 2
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [ADDR_W-1:0]    busAddr,
  input logic [PIN_COUNT-1:0] busWrData,
  input logic                 busByteWr,
  input logic                 busRd,
  input logic                 busRmw,
  input logic [PIN_COUNT-1:0] busRdData,
  input logic [PIN_COUNT-1:0] xbarOvr,
  input logic [PIN_COUNT-1:0] xbarSmb,
  input logic [PIN_COUNT-1:0] padIn,
  input logic [PIN_COUNT-1:0] padOe,
  input logic [PIN_COUNT-1:0] padOut,
  input logic [PIN_COUNT-1:0] padDigEn,
  input logic [PIN_COUNT-1:0] pinSkip
);

  assert_analog_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    (padOe & ~padDigEn) == '0);

  assert_smbus_no_high_R7: assert property (@(posedge clk) disable iff (!rstN)
    (padOe & padOut & xbarOvr & ~pinSkip & xbarSmb) == '0);

  assert_pin_read_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busAddr == '0 && !busRmw) |=> busRdData == $past(padIn & padDigEn));

  assert_read_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    !busRd |=> $stable(busRdData));

  assert_skip_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busByteWr && busAddr == ADDR_W'(3)) |=> pinSkip == $past(busWrData));

endmodule

bind gpio_port_reg gpio_port_checker #(.PIN_COUNT(PIN_COUNT), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busAddr  (busAddr),
  .busWrData(busWrData),
  .busByteWr(busByteWr),
  .busRd    (busRd),
  .busRmw   (busRmw),
  .busRdData(busRdData),
  .xbarOvr  (xbarOvr),
  .xbarSmb  (xbarSmb),
  .padIn    (padIn),
  .padOe    (padOe),
  .padOut   (padOut),
  .padDigEn (padDigEn),
  .pinSkip  (pinSkip)
);

// File: tb/sim_gpio_port_reg.sv
module sim_gpio_port_reg;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 5;

  // {pushPull, digital, skip, latch, ovr, val, smb, expOe, expOut}
  localparam logic [71:0] VECS [0:NVEC-1] = '{
    {8'h00, 8'hFF, 8'h00, 8'hA5, 8'h00, 8'h00, 8'h00, 8'h5A, 8'hA5},
    {8'hFF, 8'hFF, 8'h00, 8'h3C, 8'h00, 8'h00, 8'h00, 8'hFF, 8'h3C},
    {8'hF0, 8'hCC, 8'h00, 8'h0F, 8'h00, 8'h00, 8'h00, 8'hC0, 8'h0F},
    {8'hFF, 8'hFF, 8'h0F, 8'h00, 8'hFF, 8'hAA, 8'h33, 8'hDF, 8'hA0},
    {8'h00, 8'h0F, 8'hFF, 8'h55, 8'hFF, 8'h00, 8'hFF, 8'h0A, 8'h55}
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] busAddr = '0;
  logic [7:0] busWrData = '0;
  logic       busByteWr = 1'b0;
  logic       busBitSet = 1'b0;
  logic       busBitClr = 1'b0;
  logic [2:0] busBitIdx = '0;
  logic       busRd = 1'b0;
  logic       busRmw = 1'b0;
  logic [7:0] busRdData;
  logic [7:0] xbarOvr = '0;
  logic [7:0] xbarVal = '0;
  logic [7:0] xbarSmb = '0;
  logic [7:0] padIn = '0;
  logic [7:0] padOe;
  logic [7:0] padOut;
  logic [7:0] padDigEn;
  logic [7:0] pinSkip;

  int  checks = 0;
  int  errors = 0;
  bit  finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_port_reg u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrData(busWrData),
    .busByteWr(busByteWr), .busBitSet(busBitSet), .busBitClr(busBitClr),
    .busBitIdx(busBitIdx), .busRd(busRd), .busRmw(busRmw), .busRdData(busRdData),
    .xbarOvr(xbarOvr), .xbarVal(xbarVal), .xbarSmb(xbarSmb), .padIn(padIn),
    .padOe(padOe), .padOut(padOut), .padDigEn(padDigEn), .pinSkip(pinSkip)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic writeByte(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busByteWr = 1'b1;
    @(negedge clk);
    busByteWr = 1'b0;
  endtask

  task automatic bitOp(input logic [1:0] a, input logic [2:0] idx, input bit setNotClr);
    @(negedge clk);
    busAddr = a; busBitIdx = idx;
    busBitSet = setNotClr; busBitClr = !setNotClr;
    @(negedge clk);
    busBitSet = 1'b0; busBitClr = 1'b0;
  endtask

  task automatic readReg(input logic [1:0] a, input bit rmw, output logic [7:0] d);
    @(negedge clk);
    busAddr = a; busRmw = rmw; busRd = 1'b1;
    @(negedge clk);
    busRd = 1'b0; busRmw = 1'b0;
    d = busRdData;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    check("R1 rdData", busRdData, 8'h00);
    readReg(2'd0, 1'b1, rd); check("R1 latch", rd, 8'hFF);
    readReg(2'd1, 1'b0, rd); check("R1 pushpull", rd, 8'h00);
    readReg(2'd2, 1'b0, rd); check("R1 digital", rd, 8'hFF);
    readReg(2'd3, 1'b0, rd); check("R1 skip", rd, 8'h00);
    check("R1 padOe", padOe, 8'h00);

    // table walk: R6 R7 R9 output path
    for (int i = 0; i < NVEC; i++) begin
      writeByte(2'd1, VECS[i][71:64]);
      writeByte(2'd2, VECS[i][63:56]);
      writeByte(2'd3, VECS[i][55:48]);
      writeByte(2'd0, VECS[i][47:40]);
      xbarOvr = VECS[i][39:32];
      xbarVal = VECS[i][31:24];
      xbarSmb = VECS[i][23:16];
      @(negedge clk);
      check("R6 R7 R8 R9 padOe", padOe, VECS[i][15:8]);
      check("R6 R9 padOut", padOut, VECS[i][7:0]);
      check("R10 pinSkip", pinSkip, VECS[i][55:48]);
      check("R10 padDigEn", padDigEn, VECS[i][63:56]);
    end
    xbarOvr = '0; xbarVal = '0; xbarSmb = '0;

    // R2 readback of configuration registers
    writeByte(2'd1, 8'h96); readReg(2'd1, 1'b0, rd); check("R2 pushpull", rd, 8'h96);
    writeByte(2'd3, 8'h18); readReg(2'd3, 1'b0, rd); check("R2 skip", rd, 8'h18);
    writeByte(2'd2, 8'hFF); writeByte(2'd3, 8'h00); writeByte(2'd1, 8'h00);

    // R4 R5: latch and pin disagree
    writeByte(2'd0, 8'hC3);
    padIn = 8'h5A;
    readReg(2'd0, 1'b0, rd); check("R4 pin read", rd, 8'h5A);
    readReg(2'd0, 1'b1, rd); check("R5 latch read", rd, 8'hC3);
    padIn = 8'hFF;
    repeat (2) @(negedge clk);
    check("R4 hold", busRdData, 8'hC3);

    // R8 analog pins read 0
    writeByte(2'd2, 8'h0F);
    readReg(2'd0, 1'b0, rd); check("R8 analog read", rd, 8'h0F);
    check("R8 analog oe", padOe & 8'hF0, 8'h00);
    writeByte(2'd2, 8'hFF);

    // R3 bit operations
    writeByte(2'd0, 8'h00);
    bitOp(2'd0, 3'd5, 1'b1);
    readReg(2'd0, 1'b1, rd); check("R3 bit set", rd, 8'h20);
    bitOp(2'd0, 3'd5, 1'b0);
    bitOp(2'd0, 3'd0, 1'b1);
    readReg(2'd0, 1'b1, rd); check("R3 bit clear", rd, 8'h01);
    bitOp(2'd1, 3'd3, 1'b1);
    readReg(2'd1, 1'b0, rd); check("R3 other addr ignored", rd, 8'h00);
    readReg(2'd0, 1'b1, rd); check("R3 latch untouched", rd, 8'h01);
    @(negedge clk);
    busAddr = 2'd0; busWrData = 8'hF0; busByteWr = 1'b1; busBitClr = 1'b1; busBitIdx = 3'd7;
    @(negedge clk);
    busByteWr = 1'b0; busBitClr = 1'b0;
    readReg(2'd0, 1'b1, rd); check("R3 byte priority", rd, 8'hF0);

    // R7 SMBus overrides push-pull: high value releases the pin
    writeByte(2'd1, 8'hFF);
    xbarOvr = 8'h01; xbarVal = 8'h01; xbarSmb = 8'h01;
    @(negedge clk);
    check("R7 smbus high released", padOe & 8'h01, 8'h00);
    xbarVal = 8'h00;
    @(negedge clk);
    check("R7 smbus low driven", padOe & 8'h01, 8'h01);

    // R1 reset again restores latch
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    xbarOvr = '0;
    readReg(2'd0, 1'b1, rd); check("R1 re-reset latch", rd, 8'hFF);

    finish_run();
  end

endmodule